// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit control and status words behind a simple synchronous register bus. The bus has an address, a write enable with write data, and a read enable with registered read data. The block decodes a 4 KiB byte window. Only the lower 2 KiB, 512 words, is backed by flops. A few status words come out of reset with fixed identification values. Three of those words always read back with two flag bits set, whatever is stored in them.

One command location above the backed storage acts as a power-control port. Writing certain codes to it produces a one-cycle system reset request or system shutdown request for the platform logic. Any other access above the backed storage does nothing. It reads as zero and raises a one-cycle error pulse. Every access is a full 32-bit word access.

Top module: `sysctl_regfile`

## Requirements
- R1: Reset is synchronous and active-low. After reset, word index 0x40 (byte 0x100) holds 0x05F20121, word 0x41 (byte 0x104) holds 0x00000002, word 0x42 (byte 0x108) holds 0x05F30121, word 0x43 (byte 0x10C) holds 0x05F40121, and every other word holds zero. After reset, read data, both request outputs and the error output are zero.
- R2: A write with word index (byte address divided by 4) below 512 stores the full 32-bit write data. A read returns the stored word on `rd_data` on the clock edge after the one that samples `rd_en`. `rd_data` keeps its value when no read is issued.
- R3: A write at byte address 0x800 or above changes no stored word. This holds for the command address 0xF00 as well.
- R4: A read at byte address 0x800 or above returns zero.
- R5: A read at byte 0x100, 0x108 or 0x10C returns the stored word with bits 29 and 28 forced to 1. The stored word itself is not altered. A read at any other address, such as 0x104 or 0x110, is returned unforced.
- R6: A write to byte 0xF00 with data 1 or data 2 sets `sys_reset_req` high for exactly one cycle, registered on the edge that samples the write.
- R7: A write to byte 0xF00 with data 3 sets `sys_shutdown_req` high for exactly one cycle, with the same timing as R6. Any other data at 0xF00 raises neither request, and the two requests are never high together.
- R8: `bus_err` pulses for one cycle, registered on the sampling edge, for any read or write at byte 0x800 or above. A write to 0xF00 is the exception and raises no error. An in-range access never raises `bus_err`.
- R9: Address bits 1:0 are ignored. Byte addresses 0x13 and 0x10 reach the same word, and 0xF03 behaves as 0xF00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address within the 4 KiB window |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse for an access outside the backed storage |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_shutdown_req | output | 1 | One-cycle system shutdown request |

## Verification
A corrupted stored word shows up only when that word is read, and then on the very next cycle. The bench therefore reads each reset-valued word and reads every written word back. Aliasing from a truncated index would let out-of-range writes silently overwrite low words. To catch it, the words that 0x800, 0xFFC and 0xF00 would alias onto are read back after those writes. A wrong command decode or a stuck pulse register appears at the request outputs one cycle after the write, so the bench checks both the pulse cycle and the cycle after it.

// File: rtl/sysctl_pkg.sv
// Package: shared constants and types for the system control register file.
// Assumes 32-bit words; status addresses are word indices.
package sysctl_pkg;
    parameter int unsigned REG_W = 32;

    typedef logic [REG_W-1:0] word_t;

    // Power-control command location (byte address) and its codes.
    localparam int unsigned CMD_BYTE      = 32'hF00;
    localparam int unsigned CODE_RESET_A  = 1;
    localparam int unsigned CODE_RESET_B  = 2;
    localparam int unsigned CODE_SHUTDOWN = 3;

    // Word indices of the status words that read back with forced bits.
    localparam int unsigned STAT_WA_0 = 32'h40;
    localparam int unsigned STAT_WA_1 = 32'h42;
    localparam int unsigned STAT_WA_2 = 32'h43;
    localparam word_t       STAT_FORCE = 32'h3000_0000;

    // Reset value of a stored word, by word index.
    function automatic word_t init_word(int unsigned idx);
        case (idx)
            32'h40:  return 32'h05F2_0121;
            32'h41:  return 32'h0000_0002;
            32'h42:  return 32'h05F3_0121;
            32'h43:  return 32'h05F4_0121;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/sysctl_decode.sv
// Module: address decode for the register file.
// Purely combinational. Drops address bits 1:0, classifies the word address
// as backed, command or out of range, and flags status words.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_WORDS = 512
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [REG_W-1:0]             wr_data,
    output logic [$clog2(NUM_WORDS)-1:0] word_idx,
    output logic                         backed,
    output logic                         store_we,
    output logic                         is_status,
    output logic                         cmd_reset,
    output logic                         cmd_shutdown,
    output logic                         bad_access
);
    localparam int unsigned WA_W   = ADDR_W - 2;
    localparam int unsigned IDX_W  = $clog2(NUM_WORDS);
    localparam logic [WA_W-1:0] CMD_WA = WA_W'(CMD_BYTE >> 2);

    logic [WA_W-1:0] word_addr;
    logic            cmd_write;

    // Word address, storage index and range classification.
    always_comb begin
        word_addr = addr[ADDR_W-1:2];
        word_idx  = word_addr[IDX_W-1:0];
        backed    = ({1'b0, word_addr} < (WA_W+1)'(NUM_WORDS));
        store_we  = wr_en & backed;
        cmd_write = wr_en & (word_addr == CMD_WA);
    end

    // Status word detection for read forcing.
    always_comb begin
        is_status = (word_addr == WA_W'(STAT_WA_0)) ||
                    (word_addr == WA_W'(STAT_WA_1)) ||
                    (word_addr == WA_W'(STAT_WA_2));
    end

    // Power command decode and error classification.
    always_comb begin
        cmd_reset    = cmd_write && ((wr_data == REG_W'(CODE_RESET_A)) ||
                                     (wr_data == REG_W'(CODE_RESET_B)));
        cmd_shutdown = cmd_write && (wr_data == REG_W'(CODE_SHUTDOWN));
        bad_access   = (wr_en && !backed && !cmd_write) || (rd_en && !backed);
    end
endmodule

// File: rtl/sysctl_store.sv
// Module: flop-based word storage with per-word reset values.
// Assumes the write enable arrives already qualified as in range.
// Read is combinational; the top registers it.
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 512
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [$clog2(NUM_WORDS)-1:0] idx,
    input  logic [REG_W-1:0]             wdata,
    output logic [REG_W-1:0]             rword
);
    word_t mem_q [NUM_WORDS];

    // Load reset values, then accept one word write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                mem_q[i] <= init_word(i);
            end
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    // Combinational read port.
    assign rword = mem_q[idx];
endmodule

// File: rtl/sysctl_power.sv
// Module: power request pulse generator.
// Registers the decoded command strobes into single-cycle request pulses.
// Assumes at most one bus write per cycle.
module sysctl_power (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_reset,
    input  logic cmd_shutdown,
    output logic reset_req,
    output logic shutdown_req
);
    // Pulse each request on the edge that samples the command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req    <= 1'b0;
            shutdown_req <= 1'b0;
        end else begin
            reset_req    <= cmd_reset;
            shutdown_req <= cmd_shutdown;
        end
    end

    assert_req_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_req && shutdown_req));

    assert_reset_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(cmd_reset));

    assert_shutdown_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(cmd_shutdown));
endmodule

// File: rtl/sysctl_regfile.sv
// Module: system control register file (top).
// Decodes a 4 KiB window, backs the lower NUM_WORDS words, forces flag bits
// on status reads, turns command writes into power requests and flags
// out-of-range accesses. Read data is registered and held between reads.
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_WORDS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    output logic              bus_err,
    output logic              sys_reset_req,
    output logic              sys_shutdown_req
);
    localparam int unsigned IDX_W = $clog2(NUM_WORDS);
    localparam int unsigned WA_W  = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             backed;
    logic             store_we;
    logic             is_status;
    logic             cmd_reset;
    logic             cmd_shutdown;
    logic             bad_access;
    word_t            rword;

    sysctl_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
        .addr         (bus_addr),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .wr_data      (wr_data),
        .word_idx     (word_idx),
        .backed       (backed),
        .store_we     (store_we),
        .is_status    (is_status),
        .cmd_reset    (cmd_reset),
        .cmd_shutdown (cmd_shutdown),
        .bad_access   (bad_access)
    );

    sysctl_store #(.NUM_WORDS(NUM_WORDS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .idx   (word_idx),
        .wdata (wr_data),
        .rword (rword)
    );

    sysctl_power u_power (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_reset    (cmd_reset),
        .cmd_shutdown (cmd_shutdown),
        .reset_req    (sys_reset_req),
        .shutdown_req (sys_shutdown_req)
    );

    // Register read data: zero out of range, flag bits forced on status words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (!backed)        rd_data <= '0;
            else if (is_status) rd_data <= rword | STAT_FORCE;
            else                rd_data <= rword;
        end
    end

    // Register the one-cycle error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_err <= 1'b0;
        else        bus_err <= bad_access;
    end

    assert_oor_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_en) &&
         ({1'b0, $past(bus_addr[ADDR_W-1:2])} >= (WA_W+1)'(NUM_WORDS)))
        |-> (rd_data == '0));

    assert_status_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_en) && $past(is_status) && $past(backed))
        |-> (rd_data[29:28] == 2'b11));

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (($past(wr_en) || $past(rd_en)) &&
                     ({1'b0, $past(bus_addr[ADDR_W-1:2])} >= (WA_W+1)'(NUM_WORDS))));

    assert_no_err_with_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_reset_req || sys_shutdown_req) |-> !bus_err);
endmodule

// File: tb/sysctl_regfile_bench.sv
// Directed bench for sysctl_regfile: one task per scenario, each self-checking.
module sysctl_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        bus_err;
    logic        sys_reset_req;
    logic        sys_shutdown_req;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    sysctl_regfile u_sysctl_regfile (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_addr         (bus_addr),
        .wr_en            (wr_en),
        .wr_data          (wr_data),
        .rd_en            (rd_en),
        .rd_data          (rd_data),
        .bus_err          (bus_err),
        .sys_reset_req    (sys_reset_req),
        .sys_shutdown_req (sys_shutdown_req)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One write; returns the outputs registered by the sampling edge.
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                             output logic rq, output logic sd, output logic er);
        @(negedge clk);
        bus_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rq = sys_reset_req; sd = sys_shutdown_req; er = bus_err;
    endtask

    // One read; returns registered read data and error.
    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic er);
        @(negedge clk);
        bus_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data; er = bus_err;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] d; logic e;
        chk("R1", "rd_data after reset", rd_data, 32'h0);
        chk("R1", "reset_req after reset", {31'b0, sys_reset_req}, 32'h0);
        chk("R1", "shutdown_req after reset", {31'b0, sys_shutdown_req}, 32'h0);
        chk("R1", "err after reset", {31'b0, bus_err}, 32'h0);
        bus_read(12'h100, d, e); chk("R1", "word 0x40 (forced, R5)", d, 32'h35F2_0121);
        bus_read(12'h104, d, e); chk("R1", "word 0x41", d, 32'h0000_0002);
        bus_read(12'h108, d, e); chk("R1", "word 0x42 (forced, R5)", d, 32'h35F3_0121);
        bus_read(12'h10C, d, e); chk("R1", "word 0x43 (forced, R5)", d, 32'h35F4_0121);
        bus_read(12'h000, d, e); chk("R1", "word 0 zero", d, 32'h0);
        bus_read(12'h7FC, d, e); chk("R1", "last word zero", d, 32'h0);
        chk("R8", "no err on in-range read", {31'b0, e}, 32'h0);
    endtask

    task automatic t_read_write();
        logic [31:0] d; logic e, rq, sd;
        bus_write(12'h000, 32'hA5A5_1234, rq, sd, e);
        chk("R8", "no err on in-range write", {31'b0, e}, 32'h0);
        bus_write(12'h7FC, 32'hDEAD_BEEF, rq, sd, e);
        bus_write(12'h3A0, 32'h0F0F_F0F0, rq, sd, e);
        bus_read(12'h000, d, e); chk("R2", "word 0 readback", d, 32'hA5A5_1234);
        bus_read(12'h7FC, d, e); chk("R2", "last word readback", d, 32'hDEAD_BEEF);
        bus_read(12'h3A0, d, e); chk("R2", "mid word readback", d, 32'h0F0F_F0F0);
        repeat (3) @(negedge clk);
        chk("R2", "rd_data held without read", rd_data, 32'h0F0F_F0F0);
    endtask

    task automatic t_status_force();
        logic [31:0] d; logic e, rq, sd;
        bus_write(12'h100, 32'h0000_00FF, rq, sd, e);
        bus_read(12'h100, d, e); chk("R5", "0x100 forced", d, 32'h3000_00FF);
        bus_write(12'h104, 32'h0000_0000, rq, sd, e);
        bus_read(12'h104, d, e); chk("R5", "0x104 not forced", d, 32'h0);
        bus_write(12'h110, 32'h0000_0001, rq, sd, e);
        bus_read(12'h110, d, e); chk("R5", "0x110 not forced", d, 32'h1);
        bus_write(12'h10C, 32'hC000_0000, rq, sd, e);
        bus_read(12'h10C, d, e); chk("R5", "0x10C forced", d, 32'hF000_0000);
    endtask

    task automatic t_out_of_range();
        logic [31:0] d; logic e, rq, sd;
        bus_write(12'h800, 32'h1111_1111, rq, sd, e);
        chk("R8", "err on write 0x800", {31'b0, e}, 32'h1);
        @(negedge clk);
        chk("R8", "err is one cycle", {31'b0, bus_err}, 32'h0);
        bus_write(12'hFFC, 32'h2222_2222, rq, sd, e);
        chk("R8", "err on write 0xFFC", {31'b0, e}, 32'h1);
        bus_read(12'h000, d, e); chk("R3", "word 0 unchanged by 0x800", d, 32'hA5A5_1234);
        bus_read(12'h7FC, d, e); chk("R3", "last word unchanged by 0xFFC", d, 32'hDEAD_BEEF);
        bus_read(12'h800, d, e);
        chk("R4", "read 0x800 zero", d, 32'h0);
        chk("R8", "err on read 0x800", {31'b0, e}, 32'h1);
        bus_read(12'hF00, d, e);
        chk("R4", "read 0xF00 zero", d, 32'h0);
        chk("R8", "err on read 0xF00", {31'b0, e}, 32'h1);
    endtask

    task automatic t_power();
        logic [31:0] d; logic e, rq, sd;
        bus_write(12'h700, 32'h7777_0000, rq, sd, e);
        bus_write(12'hF00, 32'h1, rq, sd, e);
        chk("R6", "reset_req on code 1", {31'b0, rq}, 32'h1);
        chk("R6", "no shutdown on code 1", {31'b0, sd}, 32'h0);
        chk("R8", "no err on command write", {31'b0, e}, 32'h0);
        @(negedge clk);
        chk("R6", "reset_req one cycle", {31'b0, sys_reset_req}, 32'h0);
        bus_write(12'hF00, 32'h2, rq, sd, e);
        chk("R6", "reset_req on code 2", {rq, sd}, 2'b10);
        bus_write(12'hF00, 32'h3, rq, sd, e);
        chk("R7", "shutdown on code 3", {rq, sd}, 2'b01);
        chk("R8", "no err on shutdown write", {31'b0, e}, 32'h0);
        @(negedge clk);
        chk("R7", "shutdown one cycle", {31'b0, sys_shutdown_req}, 32'h0);
        bus_write(12'hF00, 32'h0, rq, sd, e);
        chk("R7", "no request on code 0", {rq, sd}, 2'b00);
        bus_write(12'hF00, 32'h4, rq, sd, e);
        chk("R7", "no request on code 4", {rq, sd}, 2'b00);
        bus_write(12'hF00, 32'h101, rq, sd, e);
        chk("R7", "no request on code 0x101", {rq, sd}, 2'b00);
        bus_read(12'h700, d, e);
        chk("R3", "alias word of 0xF00 unchanged", d, 32'h7777_0000);
    endtask

    task automatic t_low_bits();
        logic [31:0] d; logic e, rq, sd;
        bus_write(12'h013, 32'hCAFE_0013, rq, sd, e);
        bus_read(12'h010, d, e); chk("R9", "0x013 reaches word 4", d, 32'hCAFE_0013);
        bus_read(12'h011, d, e); chk("R9", "0x011 reads word 4", d, 32'hCAFE_0013);
        bus_write(12'hF03, 32'h1, rq, sd, e);
        chk("R9", "0xF03 acts as command", {rq, sd}, 2'b10);
    endtask

    task automatic t_reset_again();
        logic [31:0] d; logic e, rq, sd;
        bus_write(12'h104, 32'h5555_5555, rq, sd, e);
        apply_reset();
        bus_read(12'h104, d, e); chk("R1", "word 0x41 restored", d, 32'h2);
        bus_read(12'h000, d, e); chk("R1", "word 0 cleared", d, 32'h0);
        bus_read(12'h100, d, e); chk("R1", "word 0x40 restored", d, 32'h35F2_0121);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_read_write();
        t_status_force();
        t_out_of_range();
        t_power();
        t_low_bits();
        t_reset_again();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule